// File: doc/BRIEF.md
# Cache fill error logging unit

This unit sits beside the instruction-fill and data-fill paths of a processor memory subsystem and turns their error reports into a software-visible record and a signal to the core. Each path delivers a one-cycle event carrying three things: whether the fill came from the secondary cache or from main memory, whether the error was a corrected single-bit error or an uncorrectable double-bit error, and the physical address of the fill. A double-bit error on a fill is detected and logged but never corrected. The ECC logic, the cache arrays and exception vectoring live elsewhere. Poisoned data keeps its original check bits on the way into the cache, so later consumers see the error again.

The unit keeps a 3-bit status code, a 37-bit error address (physical bits 42 down to 6) and a sticky overflow flag. The status code names the stream and the fill source. A status stays until software clears it. Double-bit errors raise a level machine-check request when machine checks are enabled. That request is held back while the core runs in privileged mode. Single-bit load errors on the data path raise a one-cycle corrected-error interrupt instead, and they refresh only the low part of the error address.

Top module: `fill_err_log`

## Requirements
- R1: After reset, err_code is 0, err_addr is 0, err_ovf is 0, mchk_req is 0 and ce_irq is 0.
- R2: A double-bit event logs err_code 1 (instruction fill from secondary cache), 2 (data fill from secondary cache), 3 (instruction fill from memory) or 4 (data fill from memory). The code is visible from the clock edge that samples the event. A mem input of 1 means main memory.
- R3: A logged double-bit event loads all of err_addr with physical address bits [42:6]. err_addr bit 0 corresponds to physical bit 6.
- R4: A single-bit event on the data path logs err_code 5. It writes physical bits [19:6] into err_addr[13:0] and leaves err_addr[36:14] unchanged.
- R5: A single-bit event on the instruction path is ignored. It changes no output.
- R6: A nonzero err_code holds until stat_clr is 1. stat_clr alone returns it to 0. An event in the same cycle as stat_clr is captured.
- R7: err_ovf is set when an event arrives while a status is held and stat_clr is 0. It is also set when more than one loggable event arrives in one cycle. It stays set until stat_clr is 1 in a cycle with no new loss.
- R8: Within one cycle, a double-bit event is logged before a single-bit event. Among double-bit events, the instruction path is logged before the data path.
- R9: A double-bit event with mchk_en=1 posts a machine check. A double-bit event with mchk_en=0 posts none. A posted machine check stays pending until mchk_ack is 1 in a cycle with no new post.
- R10: mchk_req equals the pending machine check gated by priv_mode=0. While priv_mode is 1 the check stays pending, and it appears once priv_mode returns to 0.
- R11: Each single-bit data event gives ce_irq high for exactly the cycle after the event, whether or not it was logged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ifill_vld | input | 1 | Instruction-fill error event |
| ifill_dbl | input | 1 | 1 = double-bit, 0 = single-bit |
| ifill_mem | input | 1 | 1 = main memory, 0 = secondary cache |
| ifill_addr | input | 43 | Physical fill address |
| dfill_vld | input | 1 | Data-fill or load error event |
| dfill_dbl | input | 1 | 1 = double-bit, 0 = single-bit load error |
| dfill_mem | input | 1 | 1 = main memory, 0 = secondary cache |
| dfill_addr | input | 43 | Physical fill address |
| mchk_en | input | 1 | Machine-check enable |
| priv_mode | input | 1 | Core is in privileged mode |
| stat_clr | input | 1 | Software write-one-to-clear of status and overflow |
| mchk_ack | input | 1 | Software acknowledge of the machine check |
| err_code | output | 3 | Logged status code |
| err_addr | output | 37 | Logged physical address bits [42:6] |
| err_ovf | output | 1 | Sticky lost-event flag |
| mchk_req | output | 1 | Level machine-check request |
| ce_irq | output | 1 | Corrected-error interrupt pulse |

## Verification
The assertions assume that every input is a known value at each sampled edge once reset is released. They also assume that software strobes (stat_clr, mchk_ack) and event strobes are sampled as plain per-cycle levels, so that a strobe held for several cycles counts as several requests. The stimulus drives every input on the falling edge from a single task, so each input is stable across the rising edge. The stimulus returns events to idle between directed cases and deliberately combines clears, acknowledges and privileged-mode changes with events in the same cycle. A randomized phase draws all inputs freely but still changes them only on the falling edge.

// File: rtl/fel_pkg.sv
package fel_pkg;

  // Status codes seen by software
  typedef enum logic [2:0] {
    ST_NONE      = 3'd0,
    ST_I_L2_DBL  = 3'd1,
    ST_D_L2_DBL  = 3'd2,
    ST_I_MEM_DBL = 3'd3,
    ST_D_MEM_DBL = 3'd4,
    ST_D_LD_SGL  = 3'd5
  } fel_code_e;

  // Code for an uncorrectable fill by stream and source
  function automatic fel_code_e dbl_code(input logic is_data, input logic from_mem);
    if (from_mem) return is_data ? ST_D_MEM_DBL : ST_I_MEM_DBL;
    else          return is_data ? ST_D_L2_DBL  : ST_I_L2_DBL;
  endfunction

  // Number of loggable events raised in one cycle
  function automatic logic [1:0] count3(input logic [2:0] v);
    return {1'b0, v[0]} + {1'b0, v[1]} + {1'b0, v[2]};
  endfunction

endpackage

// File: rtl/fel_pick.sv
module fel_pick
  import fel_pkg::*;
#(
  parameter int PA_W = 43
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            i_vld,
  input  logic            i_dbl,
  input  logic            i_mem,
  input  logic [PA_W-1:0] i_addr,
  input  logic            d_vld,
  input  logic            d_dbl,
  input  logic            d_mem,
  input  logic [PA_W-1:0] d_addr,
  output logic            win_vld,
  output fel_code_e       win_code,
  output logic            win_dbl,
  output logic [PA_W-1:0] win_addr,
  output logic [1:0]      evt_cnt,
  output logic            dbl_any,
  output logic            sgl_evt
);
  localparam int NP = 2;  // path 0 = instruction (higher priority), 1 = data

  logic [NP-1:0]   p_vld, p_dbl, p_mem, dbl_ev;
  logic [PA_W-1:0] p_addr [NP];

  assign p_vld = {d_vld, i_vld};
  assign p_dbl = {d_dbl, i_dbl};
  assign p_mem = {d_mem, i_mem};
  assign p_addr[0] = i_addr;
  assign p_addr[1] = d_addr;

  for (genvar p = 0; p < NP; p++) begin : g_path
    assign dbl_ev[p] = p_vld[p] & p_dbl[p];
  end

  // Single-bit reports count only on the data (load) path
  assign sgl_evt = d_vld & ~d_dbl;
  assign dbl_any = |dbl_ev;
  assign evt_cnt = count3({dbl_ev, sgl_evt});

  always_comb begin
    win_vld  = sgl_evt;
    win_dbl  = 1'b0;
    win_code = sgl_evt ? ST_D_LD_SGL : ST_NONE;
    win_addr = d_addr;
    // Walk from lowest to highest priority so the last hit wins
    for (int p = NP - 1; p >= 0; p--) begin
      if (dbl_ev[p]) begin
        win_vld  = 1'b1;
        win_dbl  = 1'b1;
        win_code = dbl_code(p == 1, p_mem[p]);
        win_addr = p_addr[p];
      end
    end
  end

  // R8: an uncorrectable event always beats a corrected one
  assert_dbl_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_any && sgl_evt) |-> (win_code != ST_D_LD_SGL));

  // R5: an instruction single-bit report alone selects nothing
  assert_i_sgl_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (i_vld && !i_dbl && !d_vld) |-> !win_vld);

endmodule

// File: rtl/fel_log.sv
module fel_log
  import fel_pkg::*;
#(
  parameter int PA_W   = 43,
  parameter int LO_BIT = 6,
  parameter int SB_HI  = 19
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   win_vld,
  input  fel_code_e              win_code,
  input  logic                   win_dbl,
  input  logic [PA_W-1:0]        win_addr,
  input  logic [1:0]             evt_cnt,
  input  logic                   sw_clr,
  output fel_code_e              stat,
  output logic [PA_W-LO_BIT-1:0] err_addr,
  output logic                   ovf
);
  localparam int LOG_W = PA_W - LO_BIT;
  localparam int SB_W  = SB_HI - LO_BIT + 1;

  // Double-bit errors load the full block address; single-bit only the low field
  function automatic logic [LOG_W-1:0] merge_addr(input logic [LOG_W-1:0] old,
                                                  input logic [PA_W-1:0]  pa,
                                                  input logic             full);
    logic [LOG_W-1:0] r;
    r = old;
    if (full) r = pa[PA_W-1:LO_BIT];
    else      r[SB_W-1:0] = pa[SB_HI:LO_BIT];
    return r;
  endfunction

  logic busy, capture, lost;

  assign busy    = (stat != ST_NONE) && !sw_clr;
  assign capture = win_vld && !busy;
  assign lost    = (win_vld && busy) || (evt_cnt > 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat     <= ST_NONE;
      err_addr <= '0;
      ovf      <= 1'b0;
    end else begin
      if (capture) begin
        stat     <= win_code;
        err_addr <= merge_addr(err_addr, win_addr, win_dbl);
      end else if (sw_clr) begin
        stat <= ST_NONE;
      end
      ovf <= (ovf && !sw_clr) || lost;
    end
  end

  // R6: a held status is not overwritten
  assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat != ST_NONE && !sw_clr) |=> (stat == $past(stat)));

  // R7: an event against a held status is remembered
  assert_ovf_on_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat != ST_NONE && !sw_clr && evt_cnt != 2'd0) |=> ovf);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !sw_clr) |=> ovf);

  // R4: single-bit capture leaves the upper address field alone
  assert_upper_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !win_dbl) |=> (err_addr[LOG_W-1:SB_W] == $past(err_addr[LOG_W-1:SB_W])));

  // R2: only defined codes appear
  assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stat inside {ST_NONE, ST_I_L2_DBL, ST_D_L2_DBL, ST_I_MEM_DBL, ST_D_MEM_DBL, ST_D_LD_SGL});

endmodule

// File: rtl/fel_notify.sv
module fel_notify (
  input  logic clk,
  input  logic rst_n,
  input  logic dbl_any,
  input  logic sgl_evt,
  input  logic mchk_en,
  input  logic priv_mode,
  input  logic mchk_ack,
  output logic mchk_req,
  output logic ce_irq
);
  logic post, pend, ce_q;

  assign post = dbl_any && mchk_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      ce_q <= 1'b0;
    end else begin
      pend <= (pend && !mchk_ack) || post;
      ce_q <= sgl_evt;
    end
  end

  // Held back while the core runs privileged code
  assign mchk_req = pend && !priv_mode;
  assign ce_irq   = ce_q;

  // R9: the pending check survives until acknowledged
  assert_pend_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !mchk_ack) |=> pend);

  // R9: nothing is posted while machine checks are disabled
  assert_no_spurious_mchk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!post && (!pend || mchk_ack)) |=> !pend);

  // R10: leaving privileged mode releases a waiting check
  assert_priv_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !mchk_ack && priv_mode) |=> (!priv_mode -> mchk_req));

  // R11: an interrupt pulse always has a single-bit cause one cycle earlier
  assert_ce_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ce_irq |-> $past(sgl_evt));

endmodule

// File: rtl/fill_err_log.sv
module fill_err_log
  import fel_pkg::*;
#(
  parameter int PA_W   = 43,
  parameter int LO_BIT = 6,
  parameter int SB_HI  = 19
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ifill_vld,
  input  logic                   ifill_dbl,
  input  logic                   ifill_mem,
  input  logic [PA_W-1:0]        ifill_addr,
  input  logic                   dfill_vld,
  input  logic                   dfill_dbl,
  input  logic                   dfill_mem,
  input  logic [PA_W-1:0]        dfill_addr,
  input  logic                   mchk_en,
  input  logic                   priv_mode,
  input  logic                   stat_clr,
  input  logic                   mchk_ack,
  output logic [2:0]             err_code,
  output logic [PA_W-LO_BIT-1:0] err_addr,
  output logic                   err_ovf,
  output logic                   mchk_req,
  output logic                   ce_irq
);
  // Named internal events, shared by the stages and the assertions
  logic            win_vld, win_dbl, dbl_any, sgl_evt;
  fel_code_e       win_code, stat;
  logic [PA_W-1:0] win_addr;
  logic [1:0]      evt_cnt;

  fel_pick #(.PA_W(PA_W)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .i_vld    (ifill_vld),
    .i_dbl    (ifill_dbl),
    .i_mem    (ifill_mem),
    .i_addr   (ifill_addr),
    .d_vld    (dfill_vld),
    .d_dbl    (dfill_dbl),
    .d_mem    (dfill_mem),
    .d_addr   (dfill_addr),
    .win_vld  (win_vld),
    .win_code (win_code),
    .win_dbl  (win_dbl),
    .win_addr (win_addr),
    .evt_cnt  (evt_cnt),
    .dbl_any  (dbl_any),
    .sgl_evt  (sgl_evt)
  );

  fel_log #(.PA_W(PA_W), .LO_BIT(LO_BIT), .SB_HI(SB_HI)) u_log (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_vld  (win_vld),
    .win_code (win_code),
    .win_dbl  (win_dbl),
    .win_addr (win_addr),
    .evt_cnt  (evt_cnt),
    .sw_clr   (stat_clr),
    .stat     (stat),
    .err_addr (err_addr),
    .ovf      (err_ovf)
  );

  fel_notify u_notify (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbl_any   (dbl_any),
    .sgl_evt   (sgl_evt),
    .mchk_en   (mchk_en),
    .priv_mode (priv_mode),
    .mchk_ack  (mchk_ack),
    .mchk_req  (mchk_req),
    .ce_irq    (ce_irq)
  );

  assign err_code = stat;

  // R3: a double-bit capture makes the whole address follow the winner
  assert_full_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_dbl && stat == ST_NONE) |=> (err_addr == $past(win_addr[PA_W-1:LO_BIT])));

endmodule

// File: tb/test_fill_err_log.sv
module test_fill_err_log;
  timeunit 1ns;
  timeprecision 100ps;

  typedef struct {
    logic        iv, id, im;
    logic [42:0] ia;
    logic        dv, dd, dm;
    logic [42:0] da;
    logic        en, priv, clr, ack;
  } stim_t;

  typedef struct {
    string       tag;
    logic [2:0]  code;
    logic [36:0] addr;
    logic        ovf, mchk, ce;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ifill_vld = 0, ifill_dbl = 0, ifill_mem = 0;
  logic [42:0] ifill_addr = '0;
  logic dfill_vld = 0, dfill_dbl = 0, dfill_mem = 0;
  logic [42:0] dfill_addr = '0;
  logic mchk_en = 0, priv_mode = 0, stat_clr = 0, mchk_ack = 0;
  logic [2:0]  err_code;
  logic [36:0] err_addr;
  logic err_ovf, mchk_req, ce_irq;

  always #2 clk = ~clk;  // 250 MHz

  fill_err_log i_fill_err_log (
    .clk(clk), .rst_n(rst_n),
    .ifill_vld(ifill_vld), .ifill_dbl(ifill_dbl), .ifill_mem(ifill_mem), .ifill_addr(ifill_addr),
    .dfill_vld(dfill_vld), .dfill_dbl(dfill_dbl), .dfill_mem(dfill_mem), .dfill_addr(dfill_addr),
    .mchk_en(mchk_en), .priv_mode(priv_mode), .stat_clr(stat_clr), .mchk_ack(mchk_ack),
    .err_code(err_code), .err_addr(err_addr), .err_ovf(err_ovf),
    .mchk_req(mchk_req), .ce_irq(ce_irq)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  exp_t sbq[$];

  // Reference state kept by the bench
  logic [2:0]  m_code = 0;
  logic [36:0] m_addr = 0;
  logic        m_ovf = 0, m_pend = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic stim_t idle();
    stim_t s;
    s.iv = 0; s.id = 0; s.im = 0; s.ia = '0;
    s.dv = 0; s.dd = 0; s.dm = 0; s.da = '0;
    s.en = 1; s.priv = 0; s.clr = 0; s.ack = 0;
    return s;
  endfunction

  // Driver: apply one cycle of stimulus and push the expected outcome
  task automatic step(input string tag, input stim_t s);
    exp_t e;
    logic idbl, ddbl, dsgl, busy, lost;
    int   n;
    @(negedge clk);
    ifill_vld = s.iv; ifill_dbl = s.id; ifill_mem = s.im; ifill_addr = s.ia;
    dfill_vld = s.dv; dfill_dbl = s.dd; dfill_mem = s.dm; dfill_addr = s.da;
    mchk_en = s.en; priv_mode = s.priv; stat_clr = s.clr; mchk_ack = s.ack;
    idbl = s.iv && s.id;
    ddbl = s.dv && s.dd;
    dsgl = s.dv && !s.dd;
    n = int'(idbl) + int'(ddbl) + int'(dsgl);
    busy = (m_code != 0) && !s.clr;
    lost = (n > 0 && busy) || n > 1;
    if (n > 0 && !busy) begin
      if (idbl) begin
        m_code = s.im ? 3'd3 : 3'd1;
        m_addr = s.ia >> 6;
      end else if (ddbl) begin
        m_code = s.dm ? 3'd4 : 3'd2;
        m_addr = s.da >> 6;
      end else begin
        m_code = 3'd5;
        m_addr = {m_addr[36:14], s.da[19:6]};
      end
    end else if (s.clr) begin
      m_code = 0;
    end
    m_ovf  = (m_ovf && !s.clr) || lost;
    m_pend = (m_pend && !s.ack) || (s.en && (idbl || ddbl));
    e.tag = tag; e.code = m_code; e.addr = m_addr; e.ovf = m_ovf;
    e.mchk = m_pend && !s.priv; e.ce = dsgl;
    sbq.push_back(e);
  endtask

  // Monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.tag, "err_code", 64'(err_code), 64'(e.code));
        chk(e.tag, "err_addr", 64'(err_addr), 64'(e.addr));
        chk(e.tag, "err_ovf",  64'(err_ovf),  64'(e.ovf));
        chk(e.tag, "mchk_req", 64'(mchk_req), 64'(e.mchk));
        chk(e.tag, "ce_irq",   64'(ce_irq),   64'(e.ce));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    stim_t s;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "err_code", 64'(err_code), 0);
    chk("R1", "err_addr", 64'(err_addr), 0);
    chk("R1", "err_ovf",  64'(err_ovf),  0);
    chk("R1", "mchk_req", 64'(mchk_req), 0);
    chk("R1", "ce_irq",   64'(ce_irq),   0);

    // R2 R3: instruction fill, secondary cache
    s = idle(); s.iv = 1; s.id = 1; s.im = 0; s.ia = 43'h5AB_CDEF_0123; step("R2", s);
    s = idle(); s.clr = 1; s.ack = 1; step("R6", s);
    // R2 R3: data fill, memory
    s = idle(); s.dv = 1; s.dd = 1; s.dm = 1; s.da = 43'h7FF_FFFF_FFC0; step("R3", s);
    s = idle(); s.clr = 1; s.ack = 1; step("R9", s);
    // R2: instruction fill, memory
    s = idle(); s.iv = 1; s.id = 1; s.im = 1; s.ia = 43'h123_4567_89C0; step("R2", s);
    // R6 R9: clear, acknowledge and new data fill from secondary cache together
    s = idle(); s.clr = 1; s.ack = 1; s.dv = 1; s.dd = 1; s.da = 43'h0F0_F0F0_F0F0; step("R6", s);
    s = idle(); s.clr = 1; s.ack = 1; step("R6", s);
    // R4 R11: single-bit load keeps upper address field
    s = idle(); s.dv = 1; s.dd = 0; s.da = 43'h000_000F_FFC0; step("R4", s);
    s = idle(); step("R11", s);
    s = idle(); s.clr = 1; step("R6", s);
    // R5: instruction single-bit report ignored
    s = idle(); s.iv = 1; s.id = 0; s.ia = 43'h3FF_FFFF_FFFF; step("R5", s);
    s = idle(); step("R5", s);
    // R7: event while holding
    s = idle(); s.dv = 1; s.da = 43'h000_0001_2340; step("R7", s);
    s = idle(); s.dv = 1; s.da = 43'h000_0005_6780; step("R7", s);
    s = idle(); step("R7", s);
    s = idle(); s.clr = 1; step("R7", s);
    // R8: double beats single in same cycle
    s = idle(); s.iv = 1; s.id = 1; s.im = 1; s.ia = 43'h2AA_AAAA_AAC0;
    s.dv = 1; s.dd = 0; s.da = 43'h000_0003_3300; step("R8", s);
    s = idle(); s.clr = 1; s.ack = 1; step("R8", s);
    // R8: instruction double beats data double
    s = idle(); s.iv = 1; s.id = 1; s.ia = 43'h111_1111_1100;
    s.dv = 1; s.dd = 1; s.dm = 1; s.da = 43'h222_2222_2200; step("R8", s);
    s = idle(); s.clr = 1; s.ack = 1; step("R8", s);
    // R9: disabled machine check
    s = idle(); s.en = 0; s.iv = 1; s.id = 1; s.ia = 43'h044_4444_4440; step("R9", s);
    s = idle(); s.en = 0; step("R9", s);
    s = idle(); s.clr = 1; step("R9", s);
    // R10: held while privileged, then released; R9 level until ack
    s = idle(); s.priv = 1; s.dv = 1; s.dd = 1; s.da = 43'h0AB_0000_0040; step("R10", s);
    s = idle(); s.priv = 1; step("R10", s);
    s = idle(); step("R10", s);
    s = idle(); step("R9", s);
    s = idle(); s.ack = 1; s.clr = 1; step("R9", s);

    // Random phase
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      s = idle();
      s.iv = r[0] & r[1]; s.id = r[2]; s.im = r[3];
      s.dv = r[4] & r[5]; s.dd = r[6]; s.dm = r[7];
      s.en = r[8] | r[9]; s.priv = r[10] & r[11];
      s.clr = r[12] & r[13]; s.ack = r[14] & r[15];
      s.ia = {$urandom, $urandom} & 43'h7FF_FFFF_FFFF;
      s.da = {$urandom, $urandom} & 43'h7FF_FFFF_FFFF;
      step("R6", s);
    end
    s = idle(); step("R11", s);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule